// File: doc/BRIEF.md
# Byte-Coded Stack Processor Core

This block is a small multi-cycle processor with an 8-bit datapath. It fetches and runs a variable-length, byte-coded instruction set out of a 256-byte memory that holds both code and data. It has eight 8-bit registers. Register 7 serves as the stack pointer for a stack kept in that same memory. An unsigned compare records its outcome in three flags, and the conditional branches test the equality flag.

A host fills the memory through a byte-wide load port while it holds the core in reset. After reset is released the core starts at address 0. A print instruction puts a register value on an output with a one-cycle strobe. The core stops on a halt instruction or on any byte it does not recognise as an opcode. It raises a halted status in both cases and an illegal flag in the second.

Top module: `byte_stack_cpu`

## Requirements
- R1: While `rst` is high the core holds PC at 0, register 7 at 0xF4 and all other registers at 0. `halted`, `illegal`, `print_valid` and `cmp_flags` all read 0. Memory contents survive reset.
- R2: A byte on `load_data` is written to memory at `load_addr` on a clock edge where `load_we` and `rst` are both high. With `rst` low, `load_we` has no effect on memory.
- R3: Load-immediate (0x82, reg, imm) writes imm into the named register. Print (0x47, reg) drives the register value on `print_data`, with `print_valid` high for exactly one cycle. A register operand uses the low three bits of its byte.
- R4: Add (0xA0, rA, rB) and multiply (0xA2, rA, rB) write rA op rB back into rA. Both wrap modulo 256, and multiply keeps the low 8 bits of the product.
- R5: Compare (0xA7, rA, rB) clears all flags and then sets exactly one of them from an unsigned comparison. `cmp_flags` bit 2 means rA<rB, bit 1 means rA>rB and bit 0 means equal. No other instruction changes the flags.
- R6: Push (0x45, reg) decrements register 7 and then stores the register at the new stack address. Pop (0x46, reg) loads the byte at register 7 into the register and then increments register 7.
- R7: Call (0x50, reg) pushes the address of the following instruction (PC+2) and continues at the value held in the named register. Return (0x11) pops the top of the stack into PC.
- R8: Jump (0x54, reg) continues at the value held in the named register. Jump-if-equal (0x55, reg) does the same only when flag bit 0 is set, and jump-if-not-equal (0x56, reg) only when it is clear. A branch that is not taken advances PC by 2.
- R9: Halt (0x01) raises `halted`. The core then runs no more instructions and prints nothing until `rst` is asserted again.
- R10: A byte that is not one of the thirteen opcodes raises both `illegal` and `halted` in the cycle after the opcode is fetched, and the core stops.
- R11: An instruction that does not jump advances PC by 1 plus the value of opcode bits [7:6]. Counting clock edges after reset is released, an instruction with zero or one operand takes 3 cycles and one with two operands takes 4. Its result appears at the last of those edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also enables host loading |
| load_we | input | 1 | Host memory write enable (effective only during reset) |
| load_addr | input | 8 | Host memory write address |
| load_data | input | 8 | Host memory write byte |
| print_valid | output | 1 | One-cycle strobe for a print result |
| print_data | output | 8 | Printed register value |
| halted | output | 1 | Core has stopped |
| illegal | output | 1 | Core stopped on an unknown opcode |
| cmp_flags | output | 3 | Compare flags {less, greater, equal} |

## Verification
Every result of this core falls at a cycle that can be worked out from the program. The bench counts clock edges from the release of reset and adds 3 cycles for each zero- or one-operand instruction and 4 for each two-operand instruction. That gives the edge at which each print strobe and the halt are due. The scoreboard stores that cycle with each expected print value. The monitor samples on the falling edge and compares both the value and the cycle at which `print_valid` appears. Branch, call and flag behaviour is observed through which values get printed: wrong paths print a poison value, and an extra or missing print is reported.

// File: rtl/byte_cpu_pkg.sv
package byte_cpu_pkg;

    localparam int DW       = 8;
    localparam int AW       = 8;
    localparam int NREG     = 8;
    localparam int RIDX_W   = $clog2(NREG);
    localparam int SP_IDX   = 7;
    localparam logic [DW-1:0] SP_INIT = 8'hF4;

    localparam logic [7:0] OP_STOP  = 8'h01;
    localparam logic [7:0] OP_LOADI = 8'h82;
    localparam logic [7:0] OP_SHOW  = 8'h47;
    localparam logic [7:0] OP_MUL   = 8'hA2;
    localparam logic [7:0] OP_ADD   = 8'hA0;
    localparam logic [7:0] OP_CMP   = 8'hA7;
    localparam logic [7:0] OP_PUSH  = 8'h45;
    localparam logic [7:0] OP_POP   = 8'h46;
    localparam logic [7:0] OP_CALL  = 8'h50;
    localparam logic [7:0] OP_RET   = 8'h11;
    localparam logic [7:0] OP_JUMP  = 8'h54;
    localparam logic [7:0] OP_JEQ   = 8'h55;
    localparam logic [7:0] OP_JNE   = 8'h56;

    typedef enum logic [2:0] {
        ST_FETCH = 3'd0,
        ST_OPA   = 3'd1,
        ST_OPB   = 3'd2,
        ST_EXEC  = 3'd3,
        ST_HALT  = 3'd4
    } state_e;

    typedef enum logic [1:0] {
        ALU_ADD = 2'd0,
        ALU_MUL = 2'd1,
        ALU_CMP = 2'd2
    } alu_op_e;

    typedef struct packed {
        logic less;
        logic greater;
        logic equal;
    } flags_t;

    function automatic logic [1:0] operand_count(input logic [7:0] op);
        return op[7:6];
    endfunction

    function automatic logic known_opcode(input logic [7:0] op);
        case (op)
            OP_STOP, OP_LOADI, OP_SHOW, OP_MUL, OP_ADD, OP_CMP, OP_PUSH,
            OP_POP, OP_CALL, OP_RET, OP_JUMP, OP_JEQ, OP_JNE: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic alu_op_e alu_select(input logic [7:0] op);
        case (op)
            OP_MUL:  return ALU_MUL;
            OP_CMP:  return ALU_CMP;
            default: return ALU_ADD;
        endcase
    endfunction

endpackage

// File: rtl/byte_cpu_mem.sv
module byte_cpu_mem #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) store[waddr] <= wdata;
    end

    assign rdata = store[raddr];

endmodule

// File: rtl/byte_cpu_regfile.sv
module byte_cpu_regfile #(
    parameter int            NREG    = 8,
    parameter int            DW      = 8,
    parameter int            SP_IDX  = 7,
    parameter logic [DW-1:0] SP_INIT = 8'hF4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [$clog2(NREG)-1:0] ra_idx,
    input  logic [$clog2(NREG)-1:0] rb_idx,
    output logic [DW-1:0]           ra_data,
    output logic [DW-1:0]           rb_data,
    input  logic                    we,
    input  logic [$clog2(NREG)-1:0] wr_idx,
    input  logic [DW-1:0]           wr_data,
    input  logic                    sp_we,
    input  logic [DW-1:0]           sp_wdata,
    output logic [DW-1:0]           sp
);
    logic [DW-1:0] regs [NREG];

    // Stack update first, general write second: a write to the stack
    // register through the general port takes precedence.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) begin
                regs[i] <= (i == SP_IDX) ? SP_INIT : '0;
            end
        end else begin
            if (sp_we) regs[SP_IDX] <= sp_wdata;
            if (we)    regs[wr_idx] <= wr_data;
        end
    end

    assign ra_data = regs[ra_idx];
    assign rb_data = regs[rb_idx];
    assign sp      = regs[SP_IDX];

endmodule

// File: rtl/byte_cpu_alu.sv
module byte_cpu_alu
    import byte_cpu_pkg::*;
#(
    parameter int W = 8
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [W-1:0]   result,
    output flags_t         cmp
);
    logic [2*W-1:0] product;

    assign product = a * b;

    always_comb begin
        case (op)
            ALU_MUL: result = product[W-1:0];
            ALU_ADD: result = a + b;
            default: result = a;
        endcase
        cmp.less    = (a < b);
        cmp.greater = (a > b);
        cmp.equal   = (a == b);
    end

endmodule

// File: rtl/byte_stack_cpu.sv
module byte_stack_cpu
    import byte_cpu_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          load_we,
    input  logic [AW-1:0] load_addr,
    input  logic [DW-1:0] load_data,
    output logic          print_valid,
    output logic [DW-1:0] print_data,
    output logic          halted,
    output logic          illegal,
    output logic [2:0]    cmp_flags
);
    state_e               state;
    logic [AW-1:0]        pc, pc_next;
    logic [DW-1:0]        ir, opa, opb;
    flags_t               flags;

    logic [RIDX_W-1:0]    ra_idx, rb_idx;
    logic [DW-1:0]        ra_data, rb_data, sp;
    logic                 rf_we, sp_we;
    logic [DW-1:0]        rf_wdata, sp_wdata;

    logic [AW-1:0]        mem_raddr, mem_waddr, core_waddr;
    logic [DW-1:0]        mem_rdata, mem_wdata, core_wdata;
    logic                 mem_we, core_we;

    alu_op_e              alu_op;
    logic [DW-1:0]        alu_res;
    flags_t               alu_flags;

    logic                 in_exec, do_print, do_stop, set_flags;
    logic                 unused_opbits;

    assign in_exec       = (state == ST_EXEC);
    assign ra_idx        = opa[RIDX_W-1:0];
    assign rb_idx        = opb[RIDX_W-1:0];
    assign alu_op        = alu_select(ir);
    assign unused_opbits = ^{opa[DW-1:RIDX_W], opb[DW-1:RIDX_W]};

    // Memory address for the single read port, per phase
    always_comb begin
        case (state)
            ST_FETCH: mem_raddr = pc;
            ST_OPA:   mem_raddr = pc + AW'(1);
            ST_OPB:   mem_raddr = pc + AW'(2);
            default:  mem_raddr = sp;
        endcase
    end

    // Host owns the write port during reset, the core otherwise
    assign mem_we    = rst ? load_we   : core_we;
    assign mem_waddr = rst ? load_addr : core_waddr;
    assign mem_wdata = rst ? load_data : core_wdata;

    // Execute-phase decode
    always_comb begin
        pc_next    = pc + AW'(1) + AW'(operand_count(ir));
        rf_we      = 1'b0;
        rf_wdata   = alu_res;
        sp_we      = 1'b0;
        sp_wdata   = sp;
        core_we    = 1'b0;
        core_waddr = sp - AW'(1);
        core_wdata = ra_data;
        do_print   = 1'b0;
        do_stop    = 1'b0;
        set_flags  = 1'b0;
        if (in_exec) begin
            case (ir)
                OP_LOADI: begin
                    rf_we    = 1'b1;
                    rf_wdata = opb;
                end
                OP_ADD, OP_MUL: rf_we = 1'b1;
                OP_CMP:  set_flags = 1'b1;
                OP_SHOW: do_print  = 1'b1;
                OP_PUSH: begin
                    sp_we    = 1'b1;
                    sp_wdata = sp - DW'(1);
                    core_we  = 1'b1;
                end
                OP_POP: begin
                    rf_we    = 1'b1;
                    rf_wdata = mem_rdata;
                    sp_we    = 1'b1;
                    sp_wdata = sp + DW'(1);
                end
                OP_CALL: begin
                    sp_we      = 1'b1;
                    sp_wdata   = sp - DW'(1);
                    core_we    = 1'b1;
                    core_wdata = pc + AW'(2);
                    pc_next    = ra_data;
                end
                OP_RET: begin
                    pc_next  = mem_rdata;
                    sp_we    = 1'b1;
                    sp_wdata = sp + DW'(1);
                end
                OP_JUMP: pc_next = ra_data;
                OP_JEQ:  if (flags.equal)  pc_next = ra_data;
                OP_JNE:  if (!flags.equal) pc_next = ra_data;
                OP_STOP: do_stop = 1'b1;
                default: do_stop = 1'b1;
            endcase
        end
    end

    byte_cpu_mem #(.AW(AW), .DW(DW)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (mem_raddr),
        .rdata (mem_rdata)
    );

    byte_cpu_regfile #(.NREG(NREG), .DW(DW), .SP_IDX(SP_IDX), .SP_INIT(SP_INIT)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .ra_idx   (ra_idx),
        .rb_idx   (rb_idx),
        .ra_data  (ra_data),
        .rb_data  (rb_data),
        .we       (rf_we),
        .wr_idx   (ra_idx),
        .wr_data  (rf_wdata),
        .sp_we    (sp_we),
        .sp_wdata (sp_wdata),
        .sp       (sp)
    );

    byte_cpu_alu #(.W(DW)) u_alu (
        .op     (alu_op),
        .a      (ra_data),
        .b      (rb_data),
        .result (alu_res),
        .cmp    (alu_flags)
    );

    // Sequencer
    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_FETCH;
            pc          <= '0;
            ir          <= '0;
            opa         <= '0;
            opb         <= '0;
            flags       <= '0;
            halted      <= 1'b0;
            illegal     <= 1'b0;
            print_valid <= 1'b0;
            print_data  <= '0;
        end else begin
            print_valid <= 1'b0;
            case (state)
                ST_FETCH: begin
                    ir    <= mem_rdata;
                    state <= ST_OPA;
                end
                ST_OPA: begin
                    if (!known_opcode(ir)) begin
                        illegal <= 1'b1;
                        halted  <= 1'b1;
                        state   <= ST_HALT;
                    end else begin
                        opa   <= mem_rdata;
                        state <= (operand_count(ir) == 2'd2) ? ST_OPB : ST_EXEC;
                    end
                end
                ST_OPB: begin
                    opb   <= mem_rdata;
                    state <= ST_EXEC;
                end
                ST_EXEC: begin
                    pc <= pc_next;
                    if (set_flags) flags <= alu_flags;
                    if (do_print) begin
                        print_valid <= 1'b1;
                        print_data  <= ra_data;
                    end
                    if (do_stop) begin
                        halted <= 1'b1;
                        state  <= ST_HALT;
                    end else begin
                        state <= ST_FETCH;
                    end
                end
                default: state <= ST_HALT;
            endcase
        end
    end

    assign cmp_flags = {flags.less, flags.greater, flags.equal};

    // R3: a print strobe never lasts two cycles
    p_print_single_r3: assert property (@(posedge clk) disable iff (rst)
        print_valid |=> !print_valid);

    // R5: at most one compare flag is ever set
    p_flags_onehot_r5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cmp_flags));

    // R6: a push moves the stack pointer down by one
    p_push_sp_r6: assert property (@(posedge clk) disable iff (rst)
        (in_exec && ir == OP_PUSH) |=> (sp == $past(sp) - DW'(1)));

    // R7: a call continues at the register value
    p_call_target_r7: assert property (@(posedge clk) disable iff (rst)
        (in_exec && ir == OP_CALL) |=> (pc == $past(ra_data)));

    // R9: halted is held until reset
    p_halt_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted);

    // R9: nothing is printed once halted
    p_no_print_halted_r9: assert property (@(posedge clk) disable iff (rst)
        halted |-> !print_valid);

    // R10: an illegal opcode always stops the core
    p_illegal_halts_r10: assert property (@(posedge clk) disable iff (rst)
        illegal |-> halted);

endmodule

// File: tb/test_byte_stack_cpu.sv
`timescale 1ns/1ps
module test_byte_stack_cpu;

    localparam logic [7:0] I_HLT  = 8'h01, I_LDI = 8'h82, I_PRN = 8'h47,
                           I_MUL  = 8'hA2, I_ADD = 8'hA0, I_CMP = 8'hA7,
                           I_PUSH = 8'h45, I_POP = 8'h46, I_CALL = 8'h50,
                           I_RET  = 8'h11, I_JMP = 8'h54, I_JEQ = 8'h55,
                           I_JNE  = 8'h56;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       load_we = 1'b0;
    logic [7:0] load_addr = '0;
    logic [7:0] load_data = '0;
    logic       print_valid;
    logic [7:0] print_data;
    logic       halted;
    logic       illegal;
    logic [2:0] cmp_flags;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int wp = 0;
    logic [7:0] img [256];

    typedef struct {
        logic [7:0] val;
        int         cyc;
        string      req;
    } exp_t;
    exp_t sb[$];

    always #2 clk = ~clk;

    byte_stack_cpu i_byte_stack_cpu (
        .clk(clk), .rst(rst), .load_we(load_we), .load_addr(load_addr),
        .load_data(load_data), .print_valid(print_valid), .print_data(print_data),
        .halted(halted), .illegal(illegal), .cmp_flags(cmp_flags)
    );

    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic expect_print(input logic [7:0] v, input int c, input string req);
        exp_t e;
        e.val = v;
        e.cyc = c;
        e.req = req;
        sb.push_back(e);
    endtask

    // Monitor: pops the scoreboard on every print strobe
    always @(negedge clk) begin : monitor
        exp_t e;
        if (!rst && print_valid) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R9", "unexpected print", int'(print_data), 0);
            end else begin
                e = sb.pop_front();
                chk(print_data == e.val, e.req, "print value", int'(print_data), int'(e.val));
                if (e.cyc >= 0)
                    chk(cyc == e.cyc, "R11", "print cycle", cyc, e.cyc);
            end
        end
    end

    task automatic clear_img();
        for (int i = 0; i < 256; i++) img[i] = 8'h00;
        wp = 0;
    endtask
    task automatic put(input logic [7:0] b);
        img[wp] = b;
        wp++;
    endtask
    task automatic op1(input logic [7:0] o, input logic [7:0] a);
        put(o); put(a);
    endtask
    task automatic op2(input logic [7:0] o, input logic [7:0] a, input logic [7:0] b);
        put(o); put(a); put(b);
    endtask
    task automatic poison();
        op2(I_LDI, 8'd6, 8'hEE); op1(I_PRN, 8'd6); put(I_HLT);
    endtask

    task automatic reset_checks();
        @(negedge clk);
        chk(halted == 1'b0,      "R1", "halted in reset",  int'(halted), 0);
        chk(illegal == 1'b0,     "R1", "illegal in reset", int'(illegal), 0);
        chk(print_valid == 1'b0, "R1", "print in reset",   int'(print_valid), 0);
        chk(cmp_flags == 3'b000, "R1", "flags in reset",   int'(cmp_flags), 0);
    endtask

    // Load the whole image during reset (R2), then release
    task automatic boot();
        @(posedge clk); #1;
        rst = 1'b1;
        for (int i = 0; i < 256; i++) begin
            load_we = 1'b1; load_addr = 8'(i); load_data = img[i];
            @(posedge clk); #1;
        end
        load_we = 1'b0;
        reset_checks();
        @(posedge clk); #1;
        rst = 1'b0;
    endtask

    task automatic reboot_only();
        @(posedge clk); #1;
        rst = 1'b1;
        @(posedge clk); #1;
        reset_checks();
        @(posedge clk); #1;
        rst = 1'b0;
    endtask

    task automatic run_prog(output int hcyc);
        int n;
        n = 0;
        hcyc = -1;
        while (n < 3000 && hcyc < 0) begin
            @(negedge clk);
            n++;
            if (halted) hcyc = cyc;
        end
        repeat (6) @(negedge clk);
        chk(sb.size() == 0, "R9", "missing prints", sb.size(), 0);
        chk(halted == 1'b1, "R9", "halted held", int'(halted), 1);
        sb.delete();
    endtask

    initial begin : watchdog
        #(4 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : driver
        int hc;

        // Program 1: timing and print basics (R1, R3, R11)
        clear_img();
        op1(I_PRN, 8'd7);           // 0..1
        op2(I_LDI, 8'd0, 8'd8);     // 2..4
        op1(I_PRN, 8'd0);           // 5..6
        put(I_HLT);                 // 7
        boot();
        expect_print(8'hF4, 3, "R1");
        expect_print(8'h08, 10, "R3");
        run_prog(hc);
        chk(hc == 13, "R11", "halt cycle", hc, 13);
        chk(illegal == 1'b0, "R9", "halt not illegal", int'(illegal), 0);

        // R2: host writes with rst low must not reach memory
        @(posedge clk); #1;
        for (int i = 0; i < 8; i++) begin
            load_we = 1'b1; load_addr = 8'(i); load_data = 8'h00;
            @(posedge clk); #1;
        end
        load_we = 1'b0;
        reboot_only();
        expect_print(8'hF4, 3, "R2");
        expect_print(8'h08, 10, "R2");
        run_prog(hc);
        chk(hc == 13, "R2", "rerun halt cycle", hc, 13);
        chk(illegal == 1'b0, "R2", "rerun not illegal", int'(illegal), 0);

        // Program 2: arithmetic, compare, conditional branches (R4, R5, R8)
        clear_img();
        op2(I_LDI, 8'd0, 8'd200);
        op2(I_LDI, 8'd1, 8'd100);
        op2(I_ADD, 8'd0, 8'd1);     // 300 mod 256 = 44
        op1(I_PRN, 8'd0);
        op2(I_LDI, 8'd2, 8'd20);
        op2(I_LDI, 8'd3, 8'd13);
        op2(I_MUL, 8'd2, 8'd3);     // 260 mod 256 = 4
        op1(I_PRN, 8'd2);
        op2(I_LDI, 8'd4, 8'h80);
        op2(I_LDI, 8'd5, 8'h40);
        op2(I_CMP, 8'd0, 8'd1);     // 44 < 100: less
        op1(I_JEQ, 8'd4);           // not taken
        op1(I_JNE, 8'd5);           // taken to 0x40
        poison();
        wp = 8'h40;
        op2(I_CMP, 8'd1, 8'd1);     // equal
        op1(I_JNE, 8'd4);           // not taken
        op2(I_LDI, 8'd6, 8'h50);
        op1(I_JEQ, 8'd6);           // taken to 0x50
        poison();
        wp = 8'h50;
        op2(I_CMP, 8'd3, 8'd2);     // 13 > 4: greater
        put(I_HLT);
        wp = 8'h80;
        poison();
        boot();
        expect_print(8'd44, -1, "R4");
        expect_print(8'd4,  -1, "R4");
        run_prog(hc);
        chk(cmp_flags == 3'b010, "R5", "final flags greater", int'(cmp_flags), 2);

        // Program 3: stack, call/return, jump (R6, R7, R8)
        clear_img();
        op2(I_LDI, 8'd0, 8'h11);    // 0
        op1(I_PUSH, 8'd0);          // 3
        op1(I_PRN, 8'd7);           // 5  -> F3
        op1(I_POP, 8'd1);           // 7
        op1(I_PRN, 8'd1);           // 9  -> 11
        op1(I_PRN, 8'd7);           // 11 -> F4
        op2(I_LDI, 8'd2, 8'h30);    // 13
        op1(I_CALL, 8'd2);          // 16, return to 18
        op1(I_PRN, 8'd3);           // 18 -> 77
        op2(I_LDI, 8'd4, 8'h60);    // 20
        op1(I_JMP, 8'd4);           // 23
        poison();                   // 25
        wp = 8'h30;
        op1(I_PRN, 8'd7);           // -> F3
        op2(I_LDI, 8'd3, 8'h77);
        op1(I_POP, 8'd5);           // return address 0x12
        op1(I_PRN, 8'd5);
        op1(I_PUSH, 8'd5);
        put(I_RET);
        wp = 8'h60;
        op1(I_PRN, 8'd7);           // -> F4
        put(I_HLT);
        boot();
        expect_print(8'hF3, -1, "R6");
        expect_print(8'h11, -1, "R6");
        expect_print(8'hF4, -1, "R6");
        expect_print(8'hF3, -1, "R7");
        expect_print(8'h12, -1, "R7");
        expect_print(8'h77, -1, "R7");
        expect_print(8'hF4, -1, "R8");
        run_prog(hc);

        // Program 4: unknown opcode (R10)
        clear_img();
        op2(I_LDI, 8'd0, 8'd5);     // 0, cycles 1..4
        op1(I_PRN, 8'd0);           // 3, cycles 5..7
        put(8'h99);                 // 5, fetched at 8
        op1(I_PRN, 8'd0);
        put(I_HLT);
        boot();
        expect_print(8'd5, 7, "R3");
        run_prog(hc);
        chk(hc == 9, "R10", "illegal halt cycle", hc, 9);
        chk(illegal == 1'b1, "R10", "illegal raised", int'(illegal), 1);

        // R1: reset clears illegal/halted/flags again
        reboot_only();

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule